// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Entry and Return

This block is the control sequencer of a small processor. It moves each instruction through a fetch step, a decode step and an execute step, and it reports which step it is in through a 2-bit phase code. It owns the program counter and a small hardware stack of return addresses. It drives an instruction-memory request, a request to the decoder, operand read requests and an execute request. Each of these is a request/acknowledge pair, and the neighbouring blocks finish each step by acknowledging it.

A level-sensitive interrupt request is looked at only when an instruction has fully completed. If the request is active and interrupts are enabled, the sequencer spends one cycle in a fourth phase. In that cycle it pushes the address of the next instruction onto the return stack, loads a fixed service-routine address and disables interrupts. The decoder can flag a return-from-interrupt instruction, which pops the saved address and re-enables interrupts. It can also flag an enable-interrupts instruction, which allows nested service routines. Stack misuse sets sticky overflow and underflow flags.

Top module: `instr_cycle_seq`

## Requirements
- R1: While synchronous active-high reset is applied, the state is cleared: phase code 00, program counter 0, interrupts disabled, stack empty, and both sticky flags clear.
- R2: Phase codes are 00 fetch, 01 decode, 10 execute, 11 interrupt entry. Fetch requests the instruction at the program counter and holds until `imem_ack`. On that cycle it captures `imem_data`, advances the program counter by one and moves to decode. Decode presents the instruction and holds until `dec_done`, then moves to execute.
- R3: The operand mode is captured when decode completes. 00 (immediate) and 11 need no operand read. 01 (direct) needs one read. 10 (indirect) needs two reads, and the first of them is marked as the pointer lookup by `opnd_ptr`. Each read holds until `opnd_ack`. `exe_req` is raised only after all reads are done and holds until `exe_done`.
- R4: The interrupt request is sampled only in the cycle that execute completes, and it is acted on only if interrupts are enabled. A request that is active only during fetch, decode or operand reads has no effect.
- R5: An interrupt entry lasts exactly one cycle in phase 11. In that cycle the already-advanced program counter (the address after the interrupted instruction) is pushed, the program counter is loaded with `VECTOR`, and interrupts are disabled. The following phase is fetch.
- R6: A return-from-interrupt instruction pops the saved address into the program counter when its execute completes, and it sets the enable. No interrupt is taken at that boundary, even with the request active.
- R7: An enable-interrupts instruction sets the enable when its execute completes. The request is tested against the enable value held before that instruction, so the earliest possible entry is at the next boundary.
- R8: The return stack holds 8 entries in last-in first-out order. A push into a full stack is dropped and sets a sticky overflow flag.
- R9: A pop from an empty stack leaves the program counter at its already-advanced value. It sets a sticky underflow flag and still enables interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req | output | 1 | Instruction fetch request (phase fetch) |
| imem_addr | output | ADDR_W | Fetch address, the program counter |
| imem_ack | input | 1 | Instruction word valid |
| imem_data | input | INSTR_W | Instruction word |
| dec_req | output | 1 | Decode request (phase decode) |
| dec_instr | output | INSTR_W | Captured instruction for the decoder |
| dec_done | input | 1 | Decode complete, qualifies the three fields below |
| dec_opmode | input | 2 | Operand mode: 00 immediate, 01 direct, 10 indirect |
| dec_reti | input | 1 | Instruction is a return from interrupt |
| dec_eni | input | 1 | Instruction enables interrupts |
| opnd_req | output | 1 | Operand memory read request |
| opnd_ptr | output | 1 | Current read is the pointer lookup of an indirect operand |
| opnd_ack | input | 1 | Operand read complete |
| exe_req | output | 1 | Execute request |
| exe_done | input | 1 | Execute complete, marks the instruction boundary |
| irq | input | 1 | Level interrupt request |
| phase | output | 2 | Current phase code |
| int_en | output | 1 | Interrupt enable |
| stk_ovf | output | 1 | Sticky return-stack overflow |
| stk_unf | output | 1 | Sticky return-stack underflow |

## Verification
The bench keeps the request raised through fetch, decode and operand reads, and then also pulses it only during those steps. A sequencer that sampled it anywhere other than the execute boundary would enter the service routine early or from a pulse it should ignore. The bench holds the request active across a return and across the first instruction of a routine. A design that tested the new enable, or one that left interrupts enabled after entry, would re-enter at once. The bench nests routines until the tenth push, with routines of different lengths so that every saved address is distinct. The unwind then shows whether the saved address was off by one, whether the stack was first-in first-out, or whether the overflow push overwrote the top entry. A return with an empty stack checks that the program counter is not loaded with stale stack contents.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [1:0] {
      PH_FETCH  = 2'b00,
      PH_DECODE = 2'b01,
      PH_EXEC   = 2'b10,
      PH_INT    = 2'b11
   } phase_e;

   typedef enum logic [1:0] {
      OPM_IMM = 2'b00,
      OPM_DIR = 2'b01,
      OPM_IND = 2'b10,
      OPM_RSV = 2'b11
   } opmode_e;

   // memory reads an operand mode costs before execution may start
   function automatic logic [1:0] opm_reads(input logic [1:0] mode);
      case (mode)
         OPM_DIR: opm_reads = 2'd1;
         OPM_IND: opm_reads = 2'd2;
         default: opm_reads = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
   parameter int DEPTH = 8,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] top,
   output logic         empty,
   output logic         full,
   output logic         ovf,
   output logic         unf
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("seq_ret_stack: DEPTH must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("seq_ret_stack: W must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot;
         always_ff @(posedge clk) begin
            if (push && !full) slot <= din;
         end
         assign top = slot;
      end else begin : g_array
         localparam int IW = $clog2(DEPTH);
         logic [W-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (push && !full) mem[IW'(cnt)] <= din;
         end
         assign top = mem[IW'(cnt - CW'(1))];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         ovf <= 1'b0;
         unf <= 1'b0;
      end else begin
         if (push) begin
            if (full) ovf <= 1'b1;
            else      cnt <= cnt + CW'(1);
         end else if (pop) begin
            if (empty) unf <= 1'b1;
            else       cnt <= cnt - CW'(1);
         end
      end
   end

   // R8: a push into a full stack leaves the depth alone and flags overflow
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
      (push && full) |=> (ovf && full));

   // R9: a pop from an empty stack flags underflow and keeps it empty
   p_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
      (pop && !push && empty) |=> (unf && empty));

   // R8, R9: flags are sticky
   p_sticky_flags_r8: assert property (@(posedge clk) disable iff (rst)
      (ovf || unf) |=> (($past(ovf) -> ovf) && ($past(unf) -> unf)));

endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
   import seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       imem_ack,
   input  logic       dec_done,
   input  logic [1:0] dec_opmode,
   input  logic       dec_reti,
   input  logic       dec_eni,
   input  logic       opnd_ack,
   input  logic       exe_done,
   input  logic       irq,
   output logic [1:0] phase,
   output logic       int_en,
   output logic       opnd_req,
   output logic       opnd_ptr,
   output logic       exe_req,
   output logic       adv_pc,
   output logic       do_push,
   output logic       do_pop,
   output logic       ld_vec
);
   phase_e     ph_q, ph_d;
   logic       ie_q;
   logic       reti_q;
   logic       eni_q;
   logic       ind_q;
   logic [1:0] rd_left;
   logic       boundary;
   logic       take_int;

   assign phase  = ph_q;
   assign int_en = ie_q;

   always_comb begin
      opnd_req = (ph_q == PH_EXEC) && (rd_left != 2'd0);
      opnd_ptr = opnd_req && ind_q && (rd_left == 2'd2);
      exe_req  = (ph_q == PH_EXEC) && (rd_left == 2'd0);
      boundary = exe_req && exe_done;
      adv_pc   = (ph_q == PH_FETCH) && imem_ack;
      do_push  = (ph_q == PH_INT);
      ld_vec   = (ph_q == PH_INT);
      do_pop   = boundary && reti_q;
      take_int = boundary && !reti_q && irq && ie_q;

      ph_d = ph_q;
      case (ph_q)
         PH_FETCH:  if (imem_ack) ph_d = PH_DECODE;
         PH_DECODE: if (dec_done) ph_d = PH_EXEC;
         PH_EXEC:   if (boundary) ph_d = take_int ? PH_INT : PH_FETCH;
         default:   ph_d = PH_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q    <= PH_FETCH;
         ie_q    <= 1'b0;
         reti_q  <= 1'b0;
         eni_q   <= 1'b0;
         ind_q   <= 1'b0;
         rd_left <= 2'd0;
      end else begin
         ph_q <= ph_d;
         if (ph_q == PH_DECODE && dec_done) begin
            reti_q  <= dec_reti;
            eni_q   <= dec_eni;
            ind_q   <= (dec_opmode == OPM_IND);
            rd_left <= opm_reads(dec_opmode);
         end else if (opnd_req && opnd_ack) begin
            rd_left <= rd_left - 2'd1;
         end
         if (ph_q == PH_INT)
            ie_q <= 1'b0;
         else if (boundary && (reti_q || eni_q))
            ie_q <= 1'b1;
      end
   end

   // R2: decode is only ever reached from fetch
   p_order_r2: assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_DECODE) |-> ($past(ph_q) == PH_FETCH || $past(ph_q) == PH_DECODE));

   // R3: the pointer lookup is followed by one more read, never by execute
   p_ptr_then_read_r3: assert property (@(posedge clk) disable iff (rst)
      (opnd_ptr && opnd_ack) |=> (opnd_req && !opnd_ptr && !exe_req));

   // R4: interrupt entry only directly after an execute phase
   p_entry_at_boundary_r4: assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_INT) |-> ($past(ph_q) == PH_EXEC && $past(exe_done) && $past(irq)));

   // R5: entry phase lasts one cycle and leaves interrupts disabled
   p_single_entry_r5: assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_INT) |=> (ph_q == PH_FETCH && !ie_q));

   // R6: a return goes straight to fetch with interrupts enabled
   p_return_no_entry_r6: assert property (@(posedge clk) disable iff (rst)
      do_pop |=> (ph_q == PH_FETCH && ie_q));

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
   import seq_pkg::*;
#(
   parameter int              ADDR_W      = 8,
   parameter int              INSTR_W     = 16,
   parameter int              STACK_DEPTH = 8,
   parameter logic [ADDR_W-1:0] VECTOR    = 8'hF0
) (
   input  logic               clk,
   input  logic               rst,
   output logic               imem_req,
   output logic [ADDR_W-1:0]  imem_addr,
   input  logic               imem_ack,
   input  logic [INSTR_W-1:0] imem_data,
   output logic               dec_req,
   output logic [INSTR_W-1:0] dec_instr,
   input  logic               dec_done,
   input  logic [1:0]         dec_opmode,
   input  logic               dec_reti,
   input  logic               dec_eni,
   output logic               opnd_req,
   output logic               opnd_ptr,
   input  logic               opnd_ack,
   output logic               exe_req,
   input  logic               exe_done,
   input  logic               irq,
   output logic [1:0]         phase,
   output logic               int_en,
   output logic               stk_ovf,
   output logic               stk_unf
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("instr_cycle_seq: ADDR_W must be at least 2");
      end
      if (INSTR_W < 1) begin : g_bad_instr
         $error("instr_cycle_seq: INSTR_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0]  pc;
   logic [INSTR_W-1:0] ir;
   logic [ADDR_W-1:0]  stk_top;
   logic               stk_empty;
   logic               stk_full;
   logic               adv_pc, do_push, do_pop, ld_vec;

   seq_phase_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .imem_ack   (imem_ack),
      .dec_done   (dec_done),
      .dec_opmode (dec_opmode),
      .dec_reti   (dec_reti),
      .dec_eni    (dec_eni),
      .opnd_ack   (opnd_ack),
      .exe_done   (exe_done),
      .irq        (irq),
      .phase      (phase),
      .int_en     (int_en),
      .opnd_req   (opnd_req),
      .opnd_ptr   (opnd_ptr),
      .exe_req    (exe_req),
      .adv_pc     (adv_pc),
      .do_push    (do_push),
      .do_pop     (do_pop),
      .ld_vec     (ld_vec)
   );

   seq_ret_stack #(
      .DEPTH (STACK_DEPTH),
      .W     (ADDR_W)
   ) u_stack (
      .clk   (clk),
      .rst   (rst),
      .push  (do_push),
      .pop   (do_pop),
      .din   (pc),
      .top   (stk_top),
      .empty (stk_empty),
      .full  (stk_full),
      .ovf   (stk_ovf),
      .unf   (stk_unf)
   );

   // the push reads the old pc in the same edge that loads the vector
   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= '0;
         ir <= '0;
      end else begin
         if (do_pop && !stk_empty) pc <= stk_top;
         else if (ld_vec)          pc <= VECTOR;
         else if (adv_pc)          pc <= pc + ADDR_W'(1);
         if (adv_pc) ir <= imem_data;
      end
   end

   assign imem_req  = (phase == PH_FETCH);
   assign imem_addr = pc;
   assign dec_req   = (phase == PH_DECODE);
   assign dec_instr = ir;

   // R9: popping an empty stack must not move the program counter
   p_pop_empty_holds_pc_r9: assert property (@(posedge clk) disable iff (rst)
      (do_pop && stk_empty) |=> (pc == $past(pc)));

   // R5: entry fetches from the vector next
   p_vector_fetch_r5: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_INT) |=> (imem_req && imem_addr == VECTOR));

endmodule

// File: tb/test_instr_cycle_seq.sv
module test_instr_cycle_seq;

   localparam int          AW  = 8;
   localparam int          IW  = 16;
   localparam logic [7:0]  VEC = 8'hF0;

   logic          clk = 1'b0;
   logic          rst;
   logic          imem_req;
   logic [AW-1:0] imem_addr;
   logic          imem_ack;
   logic [IW-1:0] imem_data;
   logic          dec_req;
   logic [IW-1:0] dec_instr;
   logic          dec_done;
   logic [1:0]    dec_opmode;
   logic          dec_reti;
   logic          dec_eni;
   logic          opnd_req;
   logic          opnd_ptr;
   logic          opnd_ack;
   logic          exe_req;
   logic          exe_done;
   logic          irq;
   logic [1:0]    phase;
   logic          int_en;
   logic          stk_ovf;
   logic          stk_unf;

   always #10 clk = ~clk;

   instr_cycle_seq #(.ADDR_W(AW), .INSTR_W(IW), .STACK_DEPTH(8), .VECTOR(VEC)) i_instr_cycle_seq (
      .clk(clk), .rst(rst),
      .imem_req(imem_req), .imem_addr(imem_addr), .imem_ack(imem_ack), .imem_data(imem_data),
      .dec_req(dec_req), .dec_instr(dec_instr), .dec_done(dec_done), .dec_opmode(dec_opmode),
      .dec_reti(dec_reti), .dec_eni(dec_eni),
      .opnd_req(opnd_req), .opnd_ptr(opnd_ptr), .opnd_ack(opnd_ack),
      .exe_req(exe_req), .exe_done(exe_done), .irq(irq),
      .phase(phase), .int_en(int_en), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // reference model state
   int exp_pc  = 0;
   bit exp_ie  = 0;
   bit exp_ovf = 0;
   bit exp_unf = 0;
   int msp     = 0;
   int mstk [8];
   bit early_pulse = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // one full instruction; called and returning at a falling edge in fetch
   task automatic run_instr(input logic [1:0] mode, input bit reti, input bit eni,
                            input logic [IW-1:0] word);
      int  nrd;
      bit  take;
      chk("R2 fetch phase", int'(phase), 0);
      chk("R2 fetch addr", int'(imem_addr), exp_pc & 8'hFF);
      if (early_pulse) irq = 1'b1;
      @(negedge clk);
      chk("R2 fetch holds", int'(phase), 0);
      chk("R2 fetch req", int'(imem_req), 1);
      imem_ack = 1'b1; imem_data = word;
      @(negedge clk);
      imem_ack = 1'b0;
      exp_pc = (exp_pc + 1) & 8'hFF;
      chk("R2 decode phase", int'(phase), 1);
      chk("R2 decode instr", int'(dec_instr), int'(word));
      dec_done = 1'b1; dec_opmode = mode; dec_reti = reti; dec_eni = eni;
      @(negedge clk);
      dec_done = 1'b0; dec_reti = 1'b0; dec_eni = 1'b0; dec_opmode = 2'b00;
      chk("R2 execute phase", int'(phase), 2);
      nrd = (mode == 2'b01) ? 1 : (mode == 2'b10) ? 2 : 0;
      for (int i = 0; i < nrd; i++) begin
         chk("R3 operand req", int'(opnd_req), 1);
         chk("R3 pointer mark", int'(opnd_ptr), (mode == 2'b10 && i == 0) ? 1 : 0);
         chk("R3 no early exe", int'(exe_req), 0);
         opnd_ack = 1'b1;
         @(negedge clk);
         opnd_ack = 1'b0;
      end
      chk("R3 reads done", int'(opnd_req), 0);
      chk("R3 exe req", int'(exe_req), 1);
      if (early_pulse) begin
         chk("R4 still executing", int'(phase), 2);
         irq = 1'b0;
      end
      exe_done = 1'b1;
      take = 0;
      if (reti) begin
         if (msp == 0) exp_unf = 1;
         else begin msp--; exp_pc = mstk[msp]; end
         exp_ie = 1;
      end else if (irq && exp_ie) begin
         take = 1;
      end
      if (eni) exp_ie = 1;
      @(negedge clk);
      exe_done = 1'b0;
      if (take) begin
         chk("R5 entry phase", int'(phase), 3);
         chk("R5 no fetch in entry", int'(imem_req), 0);
         if (msp == 8) exp_ovf = 1;
         else begin mstk[msp] = exp_pc; msp++; end
         exp_pc = VEC;
         exp_ie = 0;
         @(negedge clk);
      end
      chk("R4 back to fetch", int'(phase), 0);
      chk("R5 R6 next addr", int'(imem_addr), exp_pc);
      chk("R5 R6 R7 enable", int'(int_en), int'(exp_ie));
      chk("R8 overflow flag", int'(stk_ovf), int'(exp_ovf));
      chk("R9 underflow flag", int'(stk_unf), int'(exp_unf));
   endtask

   initial begin
      rst = 1'b1; imem_ack = 0; imem_data = '0; dec_done = 0; dec_opmode = 0;
      dec_reti = 0; dec_eni = 0; opnd_ack = 0; exe_done = 0; irq = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 phase", int'(phase), 0);
      chk("R1 pc", int'(imem_addr), 0);
      chk("R1 enable", int'(int_en), 0);
      chk("R1 overflow", int'(stk_ovf), 0);
      chk("R1 underflow", int'(stk_unf), 0);
      rst = 1'b0;

      // R2 R3: every operand mode
      for (int m = 0; m < 4; m++) run_instr(2'(m), 0, 0, 16'hA000 + 16'(m));

      // R4: request held while disabled has no effect
      irq = 1'b1;
      run_instr(2'b01, 0, 0, 16'h1111);
      run_instr(2'b10, 0, 0, 16'h2222);

      // R9 + R6: return with empty stack, request active: no entry
      run_instr(2'b00, 1, 0, 16'h3333);

      // R5: entry with saved next address; request stays high inside routine
      run_instr(2'b01, 0, 0, 16'h4444);
      run_instr(2'b00, 0, 0, 16'h5555);
      // R6: return restores
      irq = 1'b0;
      run_instr(2'b00, 1, 0, 16'h6666);

      // R4: pulse confined to fetch..operand reads
      early_pulse = 1;
      run_instr(2'b10, 0, 0, 16'h7777);
      run_instr(2'b00, 0, 0, 16'h7778);
      early_pulse = 0;

      // R7 R8: nest until the tenth push
      irq = 1'b1;
      run_instr(2'b00, 0, 0, 16'h8000);
      for (int k = 0; k < 9; k++) begin
         for (int j = 0; j < k % 3; j++) run_instr(2'b01, 0, 0, 16'h8100);
         run_instr(2'b00, 0, 1, 16'h8200);  // R7: enable, entry not yet
         run_instr(2'b00, 0, 0, 16'h8300);  // entry here
      end
      irq = 1'b0;
      // R8: LIFO unwind, then R9 on the extra return
      for (int k = 0; k < 9; k++) run_instr(2'b00, 1, 0, 16'h9000);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule